// File: doc/BRIEF.md
# Selectable Time-Base Pulse Generator

This block is the shared timing source for the timeout logic spread across an on-chip interconnect. It produces four periodic strobes, each one clock cycle wide. Each strobe's period is four times the period of the strobe before it. Every target agent can pick one of these strobes and count its own timeout in units of that strobe.

A 3-bit base select, loaded through a small write port, sets the period of the fastest strobe. The other three strobes follow from it. All four strobes come from a single free-running counter, so each slower strobe always lands on a cycle where every faster strobe also pulses. Loading a new select restarts the counter, so the first pulse after the change arrives one full period later.

A select of zero, or any value above four, turns timeouts off across the whole network. In that case the block holds every strobe low and raises a global-disable flag.

Top module: `tbase_gen`

## Requirements
- R1: After reset the base select is 4, `tmo_off` is 0 and `tick` is 0. The first pulse on `tick[0]` arrives 4096 cycles after reset release. The first pulse on `tick[1]` arrives 16384 cycles after reset release.
- R2: For a select value s from 1 to 4, strobe `tick[k]` (k = 0 for 1X, 1 for 4X, 2 for 16X, 3 for 64X) pulses every 2^(2s+4+2k) cycles. Select 1 gives periods of 64, 256, 1024 and 4096 cycles. Select 4 gives periods of 4096, 16384, 65536 and 262144 cycles.
- R3: Every strobe pulse is exactly one clock cycle wide.
- R4: The strobes are phase aligned. Whenever `tick[k]` pulses for k > 0, `tick[k-1]` pulses in the same cycle.
- R5: A write (`sel_wr_en` = 1 at a rising edge) restarts the time base. No strobe is high in the cycle after the write. Strobe k first pulses exactly its period after the write edge, even when the written value equals the old one.
- R6: With select 0, `tmo_off` is 1 from the cycle after the write, and no strobe ever pulses.
- R7: Select values 5, 6 and 7 behave exactly like select 0.
- R8: With select 1 to 4, `tmo_off` is 0. Re-enabling from the disabled state gives a full first period on every strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_wr_en | input | 1 | Write strobe for the base select |
| sel_wr_data | input | 3 | New base select value |
| tick | output | 4 | Strobes; bit 0 is 1X, bit 3 is 64X |
| tmo_off | output | 1 | High when all timeouts are globally disabled |

## Verification
The bench targets the following faults and the symptom each one would produce:

- **Restart on write.** The bench writes a new select, and also rewrites the same value, part-way through a period. A design that kept counting would pulse early, well before a full period had elapsed.
- **Out-of-range select.** Select values 5 to 7 are applied. A design that decoded only zero as "off" would start emitting strobes, or would compute a mask wider than the counter.
- **Phase alignment and pulse width.** Every cycle of each window is compared against a bench model. A tap with a mis-sized mask would pulse at a quarter or four times its period, or would fall out of step with the faster strobes.
- **Disable and re-enable.** The bench disables the block and then enables it again. A counter that was not held at zero while disabled would give a short first period.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

    // Select field width and the largest select that enables timeouts.
    localparam int unsigned SEL_W    = 3;
    localparam int unsigned SEL_MAX  = 4;
    localparam int unsigned SEL_RST  = 4;
    // Number of strobes, log2 of the fastest base period, log2 of the spacing.
    localparam int unsigned N_TAPS   = 4;
    localparam int unsigned BASE_LOG = 6;
    localparam int unsigned STEP_LOG = 2;
    // Counter wide enough for the slowest strobe at the largest select.
    localparam int unsigned CNT_W    = BASE_LOG + STEP_LOG * ((SEL_MAX - 1) + (N_TAPS - 1));

    typedef logic [SEL_W-1:0] sel_t;
    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        sel_t sel;
    } sel_state_t;

    typedef struct packed {
        cnt_t cnt;
    } cnt_state_t;

    typedef struct packed {
        logic tick;
    } tap_state_t;

    // True when the select value enables the time base.
    function automatic logic sel_valid(sel_t s);
        return (s != '0) && (32'(s) <= SEL_MAX);
    endfunction

    // Low-bit mask whose all-ones pattern marks the end of one period of tap k.
    function automatic cnt_t tap_mask(sel_t s, int unsigned k);
        int unsigned w;
        if (!sel_valid(s)) begin
            return '1;
        end
        w = BASE_LOG + STEP_LOG * ((32'(s) - 1) + k);
        return {CNT_W{1'b1}} >> (CNT_W - w);
    endfunction

endpackage

// File: rtl/tbase_sel_reg.sv
module tbase_sel_reg
    import tbase_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  sel_t wr_data,
    output sel_t sel,
    output logic en
);

    sel_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.sel = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sel <= sel_t'(SEL_RST);
        end else begin
            st_q <= st_d;
        end
    end

    assign sel = st_q.sel;
    assign en  = sel_valid(st_q.sel);

endmodule

// File: rtl/tbase_counter.sv
module tbase_counter
    import tbase_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic restart,
    output cnt_t cnt
);

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (restart || !en) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + {{(CNT_W-1){1'b0}}, 1'b1};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;

endmodule

// File: rtl/tbase_tap.sv
module tbase_tap
    import tbase_pkg::*;
#(
    parameter int unsigned TAP_IDX = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic restart,
    input  sel_t sel,
    input  cnt_t cnt,
    output logic tick
);

    tap_state_t st_d, st_q;
    cnt_t       mask;

    always_comb begin
        mask    = tap_mask(sel, TAP_IDX);
        st_d    = st_q;
        // The pulse is registered one cycle after the low bits reach all ones.
        st_d.tick = en && !restart && ((cnt & mask) == mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.tick <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick = st_q.tick;

endmodule

// File: rtl/tbase_gen.sv
module tbase_gen
    import tbase_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_wr_en,
    input  logic [SEL_W-1:0]  sel_wr_data,
    output logic [N_TAPS-1:0] tick,
    output logic              tmo_off
);

    sel_t sel_cur;
    logic tb_en;
    cnt_t cnt;

    tbase_sel_reg u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (sel_wr_en),
        .wr_data (sel_wr_data),
        .sel     (sel_cur),
        .en      (tb_en)
    );

    tbase_counter u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (tb_en),
        .restart (sel_wr_en),
        .cnt     (cnt)
    );

    for (genvar k = 0; k < N_TAPS; k++) begin : g_tap
        tbase_tap #(.TAP_IDX(k)) u_tap (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (tb_en),
            .restart (sel_wr_en),
            .sel     (sel_cur),
            .cnt     (cnt),
            .tick    (tick[k])
        );
    end

    assign tmo_off = !tb_en;

endmodule

// File: rtl/tbase_gen_chk.sv
module tbase_gen_chk
    import tbase_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              sel_wr_en,
    input logic [SEL_W-1:0]  sel_wr_data,
    input logic [N_TAPS-1:0] tick,
    input logic              tmo_off
);

    // R6, R7: no strobe while globally disabled.
    a_r6_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_off |-> (tick == '0));

    // R3: pulses are a single cycle wide (every period is at least 64 cycles).
    a_r3_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (|tick) |=> (tick == '0));

    // R5: a write silences all strobes in the following cycle.
    a_r5_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        sel_wr_en |=> (tick == '0));

    // R7, R8: the disable flag follows the value just written.
    a_r7_off_decode: assert property (@(posedge clk) disable iff (!rst_n)
        sel_wr_en |=> (tmo_off == (($past(sel_wr_data) == '0) ||
                                   (32'($past(sel_wr_data)) > SEL_MAX))));

    // R4: slower strobes only pulse together with every faster strobe.
    for (genvar k = 1; k < N_TAPS; k++) begin : g_nest
        a_r4_phase_nested: assert property (@(posedge clk) disable iff (!rst_n)
            tick[k] |-> tick[k-1]);
    end

endmodule

bind tbase_gen tbase_gen_chk u_chk (.*);

// File: tb/tbase_gen_tb.sv
`timescale 1ns/1ps
module tbase_gen_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_wr_en = 1'b0;
    logic [2:0] sel_wr_data = 3'd0;
    logic [3:0] tick;
    logic       tmo_off;

    int vecs  = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    tbase_gen u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_wr_en   (sel_wr_en),
        .sel_wr_data (sel_wr_data),
        .tick        (tick),
        .tmo_off     (tmo_off)
    );

    // Period of strobe k for select s from the requirement table; 0 = never.
    function automatic longint period(int s, int k);
        if (s < 1 || s > 4) return 0;
        return longint'(64) << (2 * (s - 1) + 2 * k);
    endfunction

    function automatic logic [3:0] exp_tick(int s, longint c);
        logic [3:0] e;
        for (int k = 0; k < 4; k++) begin
            longint p = period(s, k);
            e[k] = (p != 0) && (c > 0) && ((c % p) == 0);
        end
        return e;
    endfunction

    task automatic chk(string req, logic [3:0] got_t, logic [3:0] exp_t,
                       logic got_o, logic exp_o, longint c);
        vecs++;
        if (got_t !== exp_t || got_o !== exp_o) begin
            fails++;
            $display("FAIL %s cycle %0d: tick=%b tmo_off=%b expected tick=%b tmo_off=%b",
                     req, c, got_t, got_o, exp_t, exp_o);
        end
    endtask

    // Checks cycles 1..n after the reference point; c counts edges since it.
    task automatic run_window(int s, int n, string req);
        logic off_e = (s < 1 || s > 4);
        for (int c = 1; c <= n; c++) begin
            @(negedge clk);
            chk(req, tick, exp_tick(s, c), tmo_off, off_e, c);
        end
    endtask

    task automatic write_sel(int v, string req);
        @(negedge clk);
        sel_wr_en   = 1'b1;
        sel_wr_data = 3'(v);
        @(negedge clk);
        sel_wr_en   = 1'b0;
        chk(req, tick, 4'b0000, tmo_off, (v < 1 || v > 4), 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset state", tick, 4'b0000, tmo_off, 1'b0, 0);
        rst_n = 1'b1;
        run_window(4, 16400, "R1 default select 4");
    endtask

    task automatic t_sel1();
        write_sel(1, "R5 write sel1");
        run_window(1, 8200, "R2 R4 R3 sel1 periods");
    endtask

    task automatic t_sel2();
        write_sel(2, "R5 write sel2");
        run_window(2, 16400, "R2 sel2 periods");
    endtask

    task automatic t_sel3();
        write_sel(3, "R5 write sel3");
        run_window(3, 4200, "R2 sel3 periods");
    endtask

    task automatic t_mid_rewrite();
        write_sel(1, "R5 first write");
        run_window(1, 100, "R5 before rewrite");
        write_sel(1, "R5 same-value rewrite");
        run_window(1, 300, "R5 restart after same value");
        write_sel(1, "R5 rewrite");
        run_window(1, 40, "R5 partial");
        write_sel(2, "R5 change to sel2");
        run_window(2, 1100, "R5 restart after change");
    endtask

    task automatic t_off();
        write_sel(0, "R6 write zero");
        run_window(0, 5000, "R6 disabled");
    endtask

    task automatic t_invalid();
        for (int v = 5; v <= 7; v++) begin
            write_sel(v, "R7 write invalid");
            run_window(v, 4200, "R7 invalid acts as off");
        end
    endtask

    task automatic t_reenable();
        write_sel(0, "R8 disable");
        run_window(0, 77, "R8 idle gap");
        write_sel(1, "R8 re-enable");
        run_window(1, 4200, "R8 full first period");
    endtask

    initial begin
        t_reset();
        t_sel1();
        t_sel2();
        t_sel3();
        t_mid_rewrite();
        t_off();
        t_invalid();
        t_reenable();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
            $finish;
        end
    end

endmodule